// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Dead Time

This block sits between a modulator and the gate drivers of one half-bridge leg. It takes a high-side command and a low-side command and produces two gate-enable outputs. Each output follows its own command in phase. The block makes sure the two switches never conduct together. It also holds both gates low for a fixed number of clock cycles before either one is allowed to turn on.

The high-side command is turned into edge pulses, which set and clear a latch. This mirrors how a floating channel receives on and off events. The low-side command passes through a padding delay line, so that both channels see the same latency from command to gate. Each channel also has a supply-good flag. The flag arrives already debounced, and while it is low the matching gate is held low.

The dead time is counted only while both gates are confirmed low. If the effective request changes while that interval is running, the count starts again. When both commands are high, both gates are held off.

Top module: `halfbridge_gate_ctrl`

## Requirements
- R1: Outputs are non-inverting: with the bridge idle and supplies good, a command going high raises its gate, and a command going low drops it.
- R2: gateHigh and gateLow are never high in the same cycle.
- R3: A gate rises only after both gates have been low for DEAD_CYCLES (default 10) consecutive cycles. On a direct handover from one side to the other, both gates are low for exactly DEAD_CYCLES cycles.
- R4: If the effective request (the pair of wanted gates) changes while the dead-time count is below DEAD_CYCLES and both gates are low, the count restarts from zero. The delayed turn-on then follows the restarted count.
- R5: When a supply-good flag is low, its gate output is low in that same cycle. The internal on state is cleared at the next clock edge, and that gate cannot be turned on.
- R6: While both commands (as seen after the input pipeline) are high, both gates are driven low and stay low until one command drops.
- R7: The high path uses rising and falling edge pulses into a set/reset latch, which holds its state when set and clear coincide. The low path is padded by LOW_PAD (default 1) register stages. As a result, both channels change their gate on the third rising clock edge after the command changes, provided the dead-time count is already complete.
- R8: While rst_n is low, both gates are low. After release, the dead-time count starts from zero, so no gate rises before DEAD_CYCLES quiet cycles have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (100 MHz nominal) |
| rst_n | input | 1 | Synchronous reset, active low |
| cmdHigh | input | 1 | High-side command, high = switch on |
| cmdLow | input | 1 | Low-side command, high = switch on |
| supplyGoodHigh | input | 1 | High-side supply above lockout threshold, debounced |
| supplyGoodLow | input | 1 | Low-side supply above lockout threshold, debounced |
| gateHigh | output | 1 | High-side gate enable |
| gateLow | output | 1 | Low-side gate enable |

## Verification
The assertions assume that all four inputs are synchronous to clk and stable at the sampling edge. They also assume the supply-good flags are already free of chatter, so any single-cycle drop is treated as a real lockout event. The stimulus changes every input only just after a falling clock edge. It holds the commands for random run lengths, and it drops the supply flags only occasionally, so that long dead-time intervals and handovers actually occur. Directed sequences add the cases that random stimulus rarely produces: both commands high together, a request change in the middle of the dead time, and a lockout while a gate is on.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Strobes from the control FSM to the gate state registers
  typedef struct packed {
    logic raiseHigh;
    logic dropHigh;
    logic raiseLow;
    logic dropLow;
  } gateStrobe_t;

endpackage

// File: rtl/hbg_control.sv
module hbg_control
  import hbg_pkg::*;
#(
  parameter int DEAD_CYCLES = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqHigh,
  input  logic        reqLow,
  input  logic        supplyGoodHigh,
  input  logic        supplyGoodLow,
  input  logic        onHigh,
  input  logic        onLow,
  output gateStrobe_t strobe
);

  localparam int QW = $clog2(DEAD_CYCLES + 1);
  localparam logic [QW-1:0] DEAD_Q = QW'(DEAD_CYCLES);

  logic [QW-1:0] quietCnt;
  logic [1:0]    prevWant;
  logic          wantHigh, wantLow;
  logic [1:0]    wantVec;

  // A side is wanted only if it alone is commanded and its supply is good
  assign wantHigh = reqHigh & ~reqLow & supplyGoodHigh;
  assign wantLow  = reqLow & ~reqHigh & supplyGoodLow;
  assign wantVec  = {wantHigh, wantLow};

  always_comb begin
    strobe = '0;
    if (onHigh) begin
      strobe.dropHigh = ~wantHigh;
    end else if (onLow) begin
      strobe.dropLow = ~wantLow;
    end else if (quietCnt == DEAD_Q) begin
      if (wantHigh)     strobe.raiseHigh = 1'b1;
      else if (wantLow) strobe.raiseLow  = 1'b1;
    end
  end

  // quietCnt counts cycles with both gates low, including the drop cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quietCnt <= '0;
      prevWant <= '0;
    end else begin
      prevWant <= wantVec;
      if (strobe.dropHigh || strobe.dropLow) begin
        quietCnt <= QW'(1);
      end else if (onHigh || onLow || strobe.raiseHigh || strobe.raiseLow) begin
        quietCnt <= '0;
      end else if (quietCnt != DEAD_Q) begin
        if (wantVec != prevWant) quietCnt <= '0;
        else                     quietCnt <= quietCnt + 1'b1;
      end
    end
  end

  // R5: a supply that is not good leaves its gate state off after the edge
  a_r5_uv_high_off: assert property (@(posedge clk) disable iff (!rst_n)
    !supplyGoodHigh |=> !onHigh);
  a_r5_uv_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    !supplyGoodLow |=> !onLow);

  // R6: both requests high forces both gate states off
  a_r6_both_req_off: assert property (@(posedge clk) disable iff (!rst_n)
    (reqHigh && reqLow) |=> (!onHigh && !onLow));

endmodule

// File: rtl/hbg_datapath.sv
module hbg_datapath
  import hbg_pkg::*;
#(
  parameter int DEAD_CYCLES = 10,
  parameter int LOW_PAD     = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdHigh,
  input  logic        cmdLow,
  input  logic        supplyGoodHigh,
  input  logic        supplyGoodLow,
  input  gateStrobe_t strobe,
  output logic        reqHigh,
  output logic        reqLow,
  output logic        onHigh,
  output logic        onLow,
  output logic        gateHigh,
  output logic        gateLow
);

  localparam int LW = $clog2(DEAD_CYCLES + 1);
  localparam logic [LW-1:0] DEAD_L = LW'(DEAD_CYCLES);

  // High path: input stage, edge pulse generator, set/reset latch
  logic hiQ, hiQd, hiLatch;
  logic setPulse, clrPulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hiQ  <= 1'b0;
      hiQd <= 1'b0;
    end else begin
      hiQ  <= cmdHigh;
      hiQd <= hiQ;
    end
  end

  assign setPulse = hiQ & ~hiQd;
  assign clrPulse = ~hiQ & hiQd;

  // Coincident set and clear leave the latch unchanged
  always_ff @(posedge clk) begin
    if (!rst_n)                       hiLatch <= 1'b0;
    else if (setPulse && !clrPulse)   hiLatch <= 1'b1;
    else if (clrPulse && !setPulse)   hiLatch <= 1'b0;
  end

  // Low path: input stage plus padding to match the latch latency
  logic [LOW_PAD:0] loPipe;

  always_ff @(posedge clk) begin
    if (!rst_n) loPipe[0] <= 1'b0;
    else        loPipe[0] <= cmdLow;
  end

  for (genvar g = 1; g <= LOW_PAD; g++) begin : g_pad
    always_ff @(posedge clk) begin
      if (!rst_n) loPipe[g] <= 1'b0;
      else        loPipe[g] <= loPipe[g-1];
    end
  end

  assign reqHigh = hiLatch;
  assign reqLow  = loPipe[LOW_PAD];

  // Gate state registers driven by control strobes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      onHigh <= 1'b0;
      onLow  <= 1'b0;
    end else begin
      if (strobe.raiseHigh)     onHigh <= 1'b1;
      else if (strobe.dropHigh) onHigh <= 1'b0;
      if (strobe.raiseLow)      onLow  <= 1'b1;
      else if (strobe.dropLow)  onLow  <= 1'b0;
    end
  end

  // Lockout acts on the outputs without waiting for a clock edge
  assign gateHigh = onHigh & supplyGoodHigh;
  assign gateLow  = onLow & supplyGoodLow;

  // Independent count of quiet cycles, used by the dead-time checks
  logic [LW-1:0] lowRun;
  always_ff @(posedge clk) begin
    if (!rst_n)                lowRun <= '0;
    else if (onHigh || onLow)  lowRun <= '0;
    else if (lowRun != DEAD_L) lowRun <= lowRun + 1'b1;
  end

  // R2: the two gates are mutually exclusive
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(gateHigh && gateLow));

  // R3: a rise only after a full quiet interval
  a_r3_dead_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(onHigh) |-> (lowRun == DEAD_L));
  a_r3_dead_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(onLow) |-> (lowRun == DEAD_L));

  // R1: a gate rises only when its own side was requested
  a_r1_follow_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(onHigh) |-> $past(reqHigh));
  a_r1_follow_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(onLow) |-> $past(reqLow));

  // R7: edge pulses set and clear the high-side latch
  a_r7_set_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    setPulse |=> hiLatch);
  a_r7_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    clrPulse |=> !hiLatch);

endmodule

// File: rtl/halfbridge_gate_ctrl.sv
module halfbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int DEAD_CYCLES = 10,
  parameter int LOW_PAD     = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmdHigh,
  input  logic cmdLow,
  input  logic supplyGoodHigh,
  input  logic supplyGoodLow,
  output logic gateHigh,
  output logic gateLow
);

  gateStrobe_t strobe;
  logic reqHigh, reqLow, onHigh, onLow;

  hbg_control #(.DEAD_CYCLES(DEAD_CYCLES)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .reqHigh       (reqHigh),
    .reqLow        (reqLow),
    .supplyGoodHigh(supplyGoodHigh),
    .supplyGoodLow (supplyGoodLow),
    .onHigh        (onHigh),
    .onLow         (onLow),
    .strobe        (strobe)
  );

  hbg_datapath #(.DEAD_CYCLES(DEAD_CYCLES), .LOW_PAD(LOW_PAD)) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmdHigh       (cmdHigh),
    .cmdLow        (cmdLow),
    .supplyGoodHigh(supplyGoodHigh),
    .supplyGoodLow (supplyGoodLow),
    .strobe        (strobe),
    .reqHigh       (reqHigh),
    .reqLow        (reqLow),
    .onHigh        (onHigh),
    .onLow         (onLow),
    .gateHigh      (gateHigh),
    .gateLow       (gateLow)
  );

endmodule

// File: tb/halfbridge_gate_ctrl_test.sv
module halfbridge_gate_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEAD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdHigh = 1'b0, cmdLow = 1'b0;
  logic supplyGoodHigh = 1'b1, supplyGoodLow = 1'b1;
  logic gateHigh, gateLow;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state (built from the requirements)
  logic mh1 = 0, mh2 = 0, ml1 = 0, ml2 = 0;
  logic mOnH = 0, mOnL = 0;
  int   mQuiet = 0;
  logic [1:0] mPrev = 2'b00;
  int   lowRunTb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halfbridge_gate_ctrl #(.DEAD_CYCLES(DEAD), .LOW_PAD(1)) uut (
    .clk(clk), .rst_n(rst_n), .cmdHigh(cmdHigh), .cmdLow(cmdLow),
    .supplyGoodHigh(supplyGoodHigh), .supplyGoodLow(supplyGoodLow),
    .gateHigh(gateHigh), .gateLow(gateLow)
  );

  function automatic logic expHigh();
    return mOnH & supplyGoodHigh;
  endfunction

  function automatic logic expLow();
    return mOnL & supplyGoodLow;
  endfunction

  task automatic modelEdge();
    logic wH, wL;
    logic [1:0] wv;
    if (!rst_n) begin
      mh1 = 0; mh2 = 0; ml1 = 0; ml2 = 0;
      mOnH = 0; mOnL = 0; mQuiet = 0; mPrev = 2'b00;
    end else begin
      wH = mh2 & ~ml2 & supplyGoodHigh;
      wL = ml2 & ~mh2 & supplyGoodLow;
      wv = {wH, wL};
      if (mOnH) begin
        if (!wH) begin mOnH = 0; mQuiet = 1; end else mQuiet = 0;
      end else if (mOnL) begin
        if (!wL) begin mOnL = 0; mQuiet = 1; end else mQuiet = 0;
      end else if (mQuiet == DEAD) begin
        if (wH) begin mOnH = 1; mQuiet = 0; end
        else if (wL) begin mOnL = 1; mQuiet = 0; end
      end else begin
        if (wv != mPrev) mQuiet = 0;
        else             mQuiet = mQuiet + 1;
      end
      mPrev = wv;
      mh2 = mh1; mh1 = cmdHigh;
      ml2 = ml1; ml1 = cmdLow;
    end
  endtask

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic h, input logic l, input logic gh, input logic gl, input string tag);
    cmdHigh = h; cmdLow = l; supplyGoodHigh = gh; supplyGoodLow = gl;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(tag, gateHigh, expHigh(), "gateHigh");
    check(tag, gateLow, expLow(), "gateLow");
    check("R2", gateHigh & gateLow, 1'b0, "both gates high");
    if (gateHigh || gateLow) lowRunTb = 0; else lowRunTb++;
  endtask

  task automatic hold(input int n, input logic h, input logic l, input logic gh, input logic gl, input string tag);
    for (int i = 0; i < n; i++) step(h, l, gh, gl, tag);
  endtask

  initial begin
    int seen;
    void'($urandom(32'd7351));

    // R8: reset holds gates low even with a command present
    rst_n = 0;
    hold(4, 1, 0, 1, 1, "R8");
    rst_n = 1;
    // R8: turn-on only after the quiet count from reset
    seen = 0;
    for (int i = 0; i < DEAD + 6; i++) begin
      step(1, 0, 1, 1, "R8");
      if (gateHigh && seen == 0) seen = i + 1;
    end
    check("R8", (seen >= DEAD) ? 1'b1 : 1'b0, 1'b1, "first rise respects quiet count after reset");

    // R1/R7: fall latency of the high side is three edges
    step(0, 0, 1, 1, "R7");
    check("R7", gateHigh, 1'b1, "high still on after 1 edge");
    step(0, 0, 1, 1, "R7");
    check("R7", gateHigh, 1'b1, "high still on after 2 edges");
    step(0, 0, 1, 1, "R7");
    check("R1", gateHigh, 1'b0, "high off after 3 edges");
    hold(DEAD + 2, 0, 0, 1, 1, "R1");
    // low side rises on the third edge too
    step(0, 1, 1, 1, "R7");
    step(0, 1, 1, 1, "R7");
    check("R7", gateLow, 1'b0, "low not yet on after 2 edges");
    step(0, 1, 1, 1, "R7");
    check("R7", gateLow, 1'b1, "low on after 3 edges");
    hold(3, 0, 1, 1, 1, "R1");

    // R3: direct handover low -> high; gap must equal DEAD
    step(1, 0, 1, 1, "R3");
    seen = -1;
    for (int i = 0; i < DEAD + 8; i++) begin
      step(1, 0, 1, 1, "R3");
      if (gateHigh && seen < 0) seen = lowRunTb_prev();
    end
    check("R3", (seen == DEAD) ? 1'b1 : 1'b0, 1'b1, "handover gap length");

    // R4: request change mid dead time restarts the count
    hold(2, 0, 0, 1, 1, "R4");
    hold(4, 0, 0, 1, 1, "R4");
    hold(DEAD + 6, 0, 1, 1, 1, "R4");
    step(0, 0, 1, 1, "R4");
    hold(5, 1, 0, 1, 1, "R4");
    hold(DEAD + 5, 0, 1, 1, 1, "R4");

    // R6: both commands high forces both low
    hold(6, 1, 1, 1, 1, "R6");
    check("R6", gateHigh | gateLow, 1'b0, "both low with both commands");
    hold(DEAD + 5, 1, 0, 1, 1, "R6");

    // R5: high-side lockout while on, then release
    step(1, 0, 0, 1, "R5");
    check("R5", gateHigh, 1'b0, "gate low same cycle as lockout");
    hold(DEAD + 4, 1, 0, 0, 1, "R5");
    check("R5", gateHigh, 1'b0, "gate stays low while locked out");
    hold(DEAD + 4, 1, 0, 1, 1, "R5");
    hold(DEAD + 4, 0, 1, 1, 0, "R5");
    check("R5", gateLow, 1'b0, "low gate blocked by lockout");
    hold(DEAD + 4, 0, 1, 1, 1, "R5");

    // Random run lengths, all requirements checked against the model
    for (int k = 0; k < 300; k++) begin
      int len;
      logic h, l, gh, gl;
      len = 1 + int'($urandom_range(0, 24));
      h = 1'($urandom_range(0, 1));
      l = 1'($urandom_range(0, 1));
      gh = ($urandom_range(0, 9) != 0);
      gl = ($urandom_range(0, 9) != 0);
      hold(len, h, l, gh, gl, "R2");
    end

    finishRun();
  end

  // Quiet-cycle count seen just before the current cycle's rise
  int lowRunLast = 0;
  always @(negedge clk) lowRunLast <= lowRunTb;
  function automatic int lowRunTb_prev();
    return lowRunLast;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

endmodule